// File: doc/BRIEF.md
# Sector Sync Interpolator with Block Status

This block follows the word position inside fixed-length optical-disc data sectors. Every 16-bit word arrives with a strobe. The block advances a word counter on each strobe and judges each sync indication against the one position where a sync belongs, which is the last word slot of the sector (`SECT_LEN-1`). What it does with a sync depends on where the sync falls:

- A sync at the expected slot closes the block normally.
- A sync that comes early can retime the counter, or it can be recorded as a short block.
- A sync that comes after the block has been lengthened always closes the block.
- When no sync arrives at the expected slot, the block either inserts a synthetic one or lets the block run long.

Each case sets its own flag in a per-block status byte. Erasure flags, an uncorrectable-error indication and the latest CRC verdict are gathered into the same byte. At every block boundary the collected flags are copied into the readable status byte and then cleared. The block also drives a halt signal that tells the downstream correction engine to skip a block whose timing was disturbed.

Top module: `sector_sync_interp`

## Requirements
- R1: The word counter advances by one on each word strobe. After a block is closed it restarts so that the next word is counted at position 0. `blk_start_o` pulses high for exactly one cycle, in the cycle after the word that closed the block, and it stays low at all other times.
- R2: A sync on the word at position `SECT_LEN-1` is accepted and closes the block. It sets none of the status bits 6, 5, 4 or 2.
- R3: If no sync arrives on the word at position `SECT_LEN-1` and `interp_en_i` is 1, a sync is inserted and the block closes. Status bit 5 (sync inserted) is set for that block.
- R4: If no sync arrives on the word at position `SECT_LEN-1` and `interp_en_i` is 0, the block does not close. Counting continues past that position and status bit 4 (block lengthened) is set.
- R5: An early sync (position below `SECT_LEN-1`) while `retime_en_i` is 1 closes the block. A sync at any position above `SECT_LEN-1` also closes it. Both cases set status bit 6 (misplaced sync, counter retimed).
- R6: An early sync while `retime_en_i` is 0 does not close the block. Counting continues and status bit 2 (short block) is set.
- R7: Status bit 1 is set for a block in which any strobed word had `erase_i` high.
- R8: Status bit 0 is set for a block in which `uncorr_i` was high in any cycle.
- R9: Status bit 7 holds the `crc_pass_i` value of the last `crc_stb_i` pulse seen during the block, and is 0 if there was none.
- R10: `stat_o` changes only in the cycle that `blk_start_o` is high. The collected flags restart empty for each new block. Bit 3 always reads 0.
- R11: Reset clears `stat_o`, `blk_start_o` and `halt_ecc_o`, and sets the counter to position 0.
- R12: `halt_ecc_o` equals status bit 6 of the most recently closed block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_stb_i | input | 1 | One incoming word this cycle |
| sync_det_i | input | 1 | The strobed word carries a detected sync |
| erase_i | input | 1 | The strobed word is flagged as an erasure |
| uncorr_i | input | 1 | Uncorrectable error reported for the current block |
| crc_stb_i | input | 1 | A CRC verdict is valid this cycle |
| crc_pass_i | input | 1 | CRC verdict: 1 = pass, 0 = fail |
| interp_en_i | input | 1 | Insert a sync when one is missing |
| retime_en_i | input | 1 | Retime the counter on an early sync |
| blk_start_o | output | 1 | One-cycle pulse when a new block begins |
| halt_ecc_o | output | 1 | Skip correction of the block just closed |
| stat_o | output | 8 | Status byte of the most recently closed block |

## Verification
The hardest case to reach is a late sync. It needs a lengthened block, which only exists when insertion is off, the expected slot passes without a sync, and a sync then arrives past that slot. The bench reaches it with a sweep. For each setting of the two enables, it places one sync at every position from 0 to a few words past the sector end, and then feeds on-time syncs until the block realigns. This also covers the chains that follow: an insertion followed by an early sync in the new block, and a short block that is later closed on time.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

    localparam int DEF_SECT_LEN = 1176;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_ONTIME,
        EV_INSERT,
        EV_EXTEND,
        EV_RETIME,
        EV_SHORT
    } sync_ev_e;

    // bit order is the visible layout of the status byte
    typedef struct packed {
        logic crc_ok;
        logic il_sync;
        logic no_sync;
        logic long_blk;
        logic rsvd;
        logic short_blk;
        logic erasure;
        logic uncorr;
    } blk_stat_t;

    function automatic blk_stat_t ev_flags(sync_ev_e ev);
        blk_stat_t f;
        f = '0;
        case (ev)
            EV_INSERT: f.no_sync   = 1'b1;
            EV_EXTEND: f.long_blk  = 1'b1;
            EV_RETIME: f.il_sync   = 1'b1;
            EV_SHORT:  f.short_blk = 1'b1;
            default:   f = '0;
        endcase
        return f;
    endfunction

    function automatic logic ev_accepts(sync_ev_e ev);
        return (ev == EV_ONTIME) || (ev == EV_INSERT) || (ev == EV_RETIME);
    endfunction

endpackage

// File: rtl/ssi_judge.sv
module ssi_judge
    import ssi_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int SYNC_POS = 1175
) (
    input  logic             word_stb,
    input  logic             sync_det,
    input  logic [CNT_W-1:0] cnt,
    input  logic             interp_en,
    input  logic             retime_en,
    output sync_ev_e         ev,
    output logic             accept
);
    localparam logic [CNT_W-1:0] POS = CNT_W'(SYNC_POS);

    always_comb begin
        ev = EV_NONE;
        if (word_stb) begin
            if (sync_det) begin
                if (cnt == POS)
                    ev = EV_ONTIME;
                else if (retime_en || (cnt > POS))
                    ev = EV_RETIME;
                else
                    ev = EV_SHORT;
            end else if (cnt == POS) begin
                ev = interp_en ? EV_INSERT : EV_EXTEND;
            end
        end
    end

    assign accept = ev_accepts(ev);

endmodule

// File: rtl/ssi_counter.sv
module ssi_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             word_stb,
    input  logic             accept,
    output logic [CNT_W-1:0] cnt,
    output logic             blk_start
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            blk_start <= 1'b0;
        end else begin
            blk_start <= accept;
            if (accept)
                cnt <= '0;
            else if (word_stb && (cnt != CNT_MAX))
                cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ssi_status.sv
module ssi_status
    import ssi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sync_ev_e  ev,
    input  logic      accept,
    input  logic      word_stb,
    input  logic      erase,
    input  logic      uncorr,
    input  logic      crc_stb,
    input  logic      crc_pass,
    output blk_stat_t stat
);
    blk_stat_t live_q;
    blk_stat_t live_nx;

    always_comb begin
        live_nx = live_q | ev_flags(ev);
        if (word_stb && erase) live_nx.erasure = 1'b1;
        if (uncorr)            live_nx.uncorr  = 1'b1;
        if (crc_stb)           live_nx.crc_ok  = crc_pass;
        live_nx.rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            stat   <= '0;
        end else if (accept) begin
            stat   <= live_nx;
            live_q <= '0;
        end else begin
            live_q <= live_nx;
        end
    end

    // R10
    stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(stat));

endmodule

// File: rtl/sector_sync_interp.sv
module sector_sync_interp
    import ssi_pkg::*;
#(
    parameter int SECT_LEN = DEF_SECT_LEN
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       word_stb_i,
    input  logic       sync_det_i,
    input  logic       erase_i,
    input  logic       uncorr_i,
    input  logic       crc_stb_i,
    input  logic       crc_pass_i,
    input  logic       interp_en_i,
    input  logic       retime_en_i,
    output logic       blk_start_o,
    output logic       halt_ecc_o,
    output logic [7:0] stat_o
);
    localparam int CNT_W    = $clog2(SECT_LEN) + 1;
    localparam int SYNC_POS = SECT_LEN - 1;
    localparam logic [CNT_W-1:0] POS = CNT_W'(SYNC_POS);

    logic [CNT_W-1:0] cnt;
    sync_ev_e         ev;
    logic             accept;
    blk_stat_t        stat;

    ssi_judge #(.CNT_W(CNT_W), .SYNC_POS(SYNC_POS)) u_judge (
        .word_stb (word_stb_i),
        .sync_det (sync_det_i),
        .cnt      (cnt),
        .interp_en(interp_en_i),
        .retime_en(retime_en_i),
        .ev       (ev),
        .accept   (accept)
    );

    ssi_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .word_stb (word_stb_i),
        .accept   (accept),
        .cnt      (cnt),
        .blk_start(blk_start_o)
    );

    ssi_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .accept  (accept),
        .word_stb(word_stb_i),
        .erase   (erase_i),
        .uncorr  (uncorr_i),
        .crc_stb (crc_stb_i),
        .crc_pass(crc_pass_i),
        .stat    (stat)
    );

    assign stat_o     = stat;
    assign halt_ecc_o = stat.il_sync;

    // R2
    ontime_close_chk: assert property (@(posedge clk) disable iff (rst)
        (word_stb_i && sync_det_i && cnt == POS) |=> (blk_start_o && !stat_o[6]));

    // R3
    insert_close_chk: assert property (@(posedge clk) disable iff (rst)
        (word_stb_i && !sync_det_i && interp_en_i && cnt == POS) |=> (blk_start_o && stat_o[5]));

    // R5
    retime_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (word_stb_i && sync_det_i && retime_en_i && cnt != POS) |=> (blk_start_o && halt_ecc_o));

    // R6
    short_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (word_stb_i && sync_det_i && !retime_en_i && cnt < POS) |=> !blk_start_o);

endmodule

// File: tb/sector_sync_interp_bench.sv
module sector_sync_interp_bench;
    localparam int SECT_LEN = 12;
    localparam int POS      = SECT_LEN - 1;
    localparam int CNT_W    = $clog2(SECT_LEN) + 1;
    localparam int MAXC     = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic word_stb = 0, sync_det = 0, erase = 0, uncorr = 0;
    logic crc_stb = 0, crc_pass = 0, interp_en = 0, retime_en = 0;
    logic blk_start, halt_ecc;
    logic [7:0] stat;

    int n_chk = 0;
    int n_err = 0;
    int m_cnt = 0;
    logic [7:0] m_live = '0;
    logic [7:0] m_stat = '0;

    always #2.5 clk = ~clk;

    sector_sync_interp #(.SECT_LEN(SECT_LEN)) u_sector_sync_interp (
        .clk(clk), .rst(rst),
        .word_stb_i(word_stb), .sync_det_i(sync_det), .erase_i(erase),
        .uncorr_i(uncorr), .crc_stb_i(crc_stb), .crc_pass_i(crc_pass),
        .interp_en_i(interp_en), .retime_en_i(retime_en),
        .blk_start_o(blk_start), .halt_ecc_o(halt_ecc), .stat_o(stat)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string bit_tag(input int b);
        case (b)
            7: return "R9";
            6: return "R5";
            5: return "R3";
            4: return "R4";
            3: return "R10";
            2: return "R6";
            1: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check_outputs(input bit acc, input string tag);
        chk(blk_start == acc, tag, int'(blk_start), int'(acc));
        if (acc) begin
            for (int b = 0; b < 8; b++)
                chk(stat[b] == m_stat[b], bit_tag(b), int'(stat[b]), int'(m_stat[b]));
        end else begin
            chk(stat == m_stat, "R10", int'(stat), int'(m_stat));
        end
        chk(halt_ecc == m_stat[6], "R12", int'(halt_ecc), int'(m_stat[6]));
    endtask

    task automatic send_word(input bit sy, input bit er, input bit unc, output bit acc);
        logic [7:0] set;
        string tag;
        set = '0;
        acc = 1'b0;
        tag = "R1";
        @(negedge clk);
        word_stb = 1; sync_det = sy; erase = er; uncorr = unc;
        if (sy && m_cnt == POS) begin
            acc = 1; tag = "R2";
        end else if (sy && (m_cnt > POS || retime_en)) begin
            acc = 1; set[6] = 1; tag = "R5";
        end else if (sy) begin
            set[2] = 1; tag = "R6";
        end else if (m_cnt == POS) begin
            if (interp_en) begin acc = 1; set[5] = 1; tag = "R3"; end
            else begin set[4] = 1; tag = "R4"; end
        end
        if (er)  set[1] = 1;
        if (unc) set[0] = 1;
        m_live = m_live | set;
        if (acc) begin
            m_stat = m_live; m_live = '0; m_cnt = 0;
        end else if (m_cnt < MAXC) begin
            m_cnt++;
        end
        @(negedge clk);
        word_stb = 0; sync_det = 0; erase = 0; uncorr = 0;
        check_outputs(acc, tag);
    endtask

    task automatic send_crc(input bit pass);
        @(negedge clk);
        crc_stb = 1; crc_pass = pass;
        m_live[7] = pass;
        @(negedge clk);
        crc_stb = 0; crc_pass = 0;
        check_outputs(1'b0, "R9");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        bit acc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11: reset state
        chk(stat == 8'h00, "R11", int'(stat), 0);
        chk(blk_start == 1'b0, "R11", int'(blk_start), 0);
        chk(halt_ecc == 1'b0, "R11", int'(halt_ecc), 0);

        // R2 / R1: clean on-time block
        interp_en = 1; retime_en = 1;
        for (int i = 0; i <= POS; i++) send_word(i == POS, 1'b0, 1'b0, acc);
        chk(stat[3] == 1'b0, "R10", int'(stat[3]), 0);

        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int p = 0; p <= SECT_LEN + 2; p++) begin
                bit done;
                interp_en = cfg[0];
                retime_en = cfg[1];
                send_crc(p[0]);
                done = 0;
                for (int i = 0; !done && i < 200; i++) begin
                    bit sy;
                    sy = (i == p) || (i > p && m_cnt == POS);
                    send_word(sy, ((i + p) % 7) == 3, ((3 * i + p) % 11) == 5, acc);
                    if (acc && i >= p) done = 1;
                end
                chk(done, "R1", int'(done), 1);
            end
        end

        // R11: reset mid-block clears everything
        interp_en = 0; retime_en = 0;
        for (int i = 0; i < 4; i++) send_word(1'b0, 1'b1, 1'b1, acc);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        m_cnt = 0; m_live = '0; m_stat = '0;
        @(negedge clk);
        chk(stat == 8'h00, "R11", int'(stat), 0);
        for (int i = 0; i <= POS; i++) send_word(i == POS, 1'b0, 1'b0, acc);
        chk(stat == 8'h00, "R11", int'(stat), 0);

        finish_run();
    end

endmodule